// File: doc/BRIEF.md
# Multilevel Second-Order Noise-Shaping Modulator with Triangular Dither

This block turns a stream of oversampled, signed audio samples into a coarse 17-level code stream for a multilevel conversion stage. It runs once per clock enable, and the enable is expected to pulse at 128 times the audio frame rate. On each enable the block takes one input sample and produces one output code. Two saturating integrators form a second-order loop. The quantization error is pushed out of the audio band with a (1 - z^-1)^2 shape, so the long-run average of the codes follows the input.

Ahead of the quantizer, the block can add a pseudo-random offset with a triangular distribution spanning about one quantizer step either way. This keeps the residual error from settling into tones. Two independent shift-register generators each supply a uniform value, and the two values are summed. When the dither is switched off, the generators keep stepping but their sum is not applied, so the loop becomes fully deterministic.

Top module: `ms_modulator`

## Requirements
- R1: Synchronous active-low reset clears both integrators, the output code and `valid_o` to zero. It also loads the two generators with their seeds: 16'hACE1 for generator A and 16'h1D2B for generator B.
- R2: Each cycle with `en_i` high, `valid_o` is high in the following cycle and `code_o` holds the new code. `valid_o` is low after every cycle without `en_i`.
- R3: `code_o` is a 5-bit two's-complement value that always lies in -8..+8, which gives 17 levels.
- R4: The quantizer sums integrator 2 and the dither (s = i2 + d). The new code is floor((s + 2048) / 4096), clamped to -8..+8. One quantizer step is 4096 input units.
- R5: On each enable, with V = 4096 * new code and x the sample, the integrators update as i1' = sat(i1 + x - V), then i2' = sat(i2 + i1' - V). The second update uses the already-updated i1'.
- R6: Both integrators saturate at +/-524287 and never wrap, even under a sustained full-scale input.
- R7: Each generator is a 16-bit shift-left register that shifts in the XOR of the bits selected by a mask: 16'hB400 for generator A, 16'hD008 for generator B. The dither is the sign-extended sum of the low 12 bits of each generator. Its range is -4096..+4094, and both generators step on every enable.
- R8: While `dith_en_i` is low the applied dither is zero, but the generators still step on each enable.
- R9: In a cycle without `en_i`, the sample is ignored and the code, integrators and generators all hold.
- R10: With the dither disabled and a zero input after reset, every output code is 0.
- R11: For a constant input, the mean of the codes over 4096 enables, times 4096, is within 200 of the input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Oversampled update enable |
| dith_en_i | input | 1 | Apply triangular dither when high |
| sample_i | input | 16 | Signed input sample |
| code_o | output | 5 | Signed output code, -8..+8 |
| valid_o | output | 1 | High for the cycle after each enable |

## Verification
Under overload, the quantizer's clamp at +/-8 and the integrators' saturation both act on the same enable, and the dither can move the unclamped code across the clamp boundary in that same cycle. The bench provokes this by holding the sample at full scale, first positive and then negative, with the dither enabled. It judges every code against a bench reference model that applies the clamp and the saturation independently. Enables arrive with random gaps throughout, so holding behaviour is checked between updates.

// File: rtl/msdm_pkg.sv
// Package: shared types and constants of the multilevel modulator.
// Assumes a 17-level signed code carried in a 5-bit two's-complement field.
package msdm_pkg;
    localparam int CODE_W   = 5;
    localparam int CODE_LIM = 8;
    typedef logic signed [CODE_W-1:0] code_t;
endpackage

// File: rtl/msdm_lfsr.sv
// Module: Fibonacci shift register used as a uniform noise source.
// Shifts left on step_i, inserting the XOR of the masked state bits at bit 0.
// Assumes a nonzero seed; exposes only the low OW bits.
module msdm_lfsr #(
    parameter int          W    = 16,
    parameter int          OW   = 12,
    parameter logic [W-1:0] MASK = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    output logic [OW-1:0] low_o
);
    logic [W-1:0] st_q;

    // State register: reseed on reset, advance once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEED;
        end else if (step_i) begin
            st_q <= {st_q[W-2:0], ^(st_q & MASK)};
        end
    end

    assign low_o = st_q[OW-1:0];
endmodule

// File: rtl/msdm_dither.sv
// Module: triangular-PDF dither from two independent uniform sources.
// Each source gives a signed DBW-bit value; their sum spans about +/- one
// quantizer step. Output is forced to zero when enable_i is low, while the
// sources still step so the sequence position does not depend on enable_i.
module msdm_dither #(
    parameter int          W      = 16,
    parameter int          DBW    = 12,
    parameter logic [W-1:0] MASK_A = 16'hB400,
    parameter logic [W-1:0] SEED_A = 16'hACE1,
    parameter logic [W-1:0] MASK_B = 16'hD008,
    parameter logic [W-1:0] SEED_B = 16'h1D2B
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_i,
    input  logic                  enable_i,
    output logic signed [DBW:0]   dither_o
);
    localparam int NSRC = 2;

    logic [DBW-1:0] low_w [NSRC];

    // One shift-register source per generate slot, each with its own mask and seed.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam logic [W-1:0] M = (g == 0) ? MASK_A : MASK_B;
        localparam logic [W-1:0] S = (g == 0) ? SEED_A : SEED_B;
        msdm_lfsr #(.W(W), .OW(DBW), .MASK(M), .SEED(S)) u_lfsr (
            .clk    (clk),
            .rst_n  (rst_n),
            .step_i (step_i),
            .low_o  (low_w[g])
        );
    end

    logic signed [DBW:0] sum_w;

    // Sum of two sign-extended uniform values, gated by the enable.
    always_comb begin
        sum_w    = $signed({low_w[0][DBW-1], low_w[0]}) + $signed({low_w[1][DBW-1], low_w[1]});
        dither_o = enable_i ? sum_w : '0;
    end
endmodule

// File: rtl/msdm_quant.sv
// Module: 17-level rounding quantizer.
// Rounds s_i to the nearest multiple of 2^SH (ties upward) and clamps the
// resulting level to +/- CODE_LIM. Purely combinational.
module msdm_quant
    import msdm_pkg::*;
#(
    parameter int SW = 22,
    parameter int SH = 12
) (
    input  logic signed [SW-1:0] s_i,
    output code_t                code_o
);
    localparam logic signed [SW:0] HALF_S = (SW+1)'(1 << (SH - 1));
    localparam logic signed [SW:0] QMAX_S = (SW+1)'(CODE_LIM);
    localparam logic signed [SW:0] QMIN_S = -QMAX_S;

    logic signed [SW:0] ext_w;
    logic signed [SW:0] lvl_w;

    // Round to nearest level, then clamp to the code range.
    always_comb begin
        ext_w = $signed({s_i[SW-1], s_i}) + HALF_S;
        lvl_w = ext_w >>> SH;
        if (lvl_w > QMAX_S) begin
            code_o = code_t'(CODE_LIM);
        end else if (lvl_w < QMIN_S) begin
            code_o = code_t'(-CODE_LIM);
        end else begin
            code_o = lvl_w[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/msdm_loop.sv
// Module: second-order loop with saturating integrators and registered code.
// On each enable: code = Q(i2 + dither); i1 += x - V; i2 += i1(new) - V,
// with V = code * 2^SH. Integrators clamp at +/- ILIM.
// Assumes IW >= CODE_W + SH + 1 and IW > DW.
module msdm_loop
    import msdm_pkg::*;
#(
    parameter int DW   = 16,
    parameter int IW   = 21,
    parameter int SH   = 12,
    parameter int ILIM = 524287
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [SH:0]   dither_i,
    output code_t                code_o,
    output logic                 valid_o,
    output logic signed [IW-1:0] i1_o,
    output logic signed [IW-1:0] i2_o
);
    localparam int XW = IW + 2;
    localparam int SW = IW + 1;
    localparam int FPAD = IW - CODE_W - SH;
    localparam logic signed [XW-1:0] LIM_P = XW'(ILIM);
    localparam logic signed [XW-1:0] LIM_N = -LIM_P;

    logic signed [IW-1:0] i1_q, i2_q;
    logic signed [SW-1:0] s_w;
    code_t                q_w;
    logic signed [IW-1:0] fb_w;
    logic signed [XW-1:0] a1_w, a2_w;
    logic signed [IW-1:0] i1_n, i2_n;

    // Clamp a wide sum to the integrator limits.
    function automatic logic signed [IW-1:0] sat_f(input logic signed [XW-1:0] v);
        if (v > LIM_P) begin
            return LIM_P[IW-1:0];
        end else if (v < LIM_N) begin
            return LIM_N[IW-1:0];
        end
        return v[IW-1:0];
    endfunction

    // Quantizer input: second integrator plus dither.
    assign s_w = $signed({i2_q[IW-1], i2_q}) + $signed({{(SW-SH-1){dither_i[SH]}}, dither_i});

    msdm_quant #(.SW(SW), .SH(SH)) u_quant (
        .s_i    (s_w),
        .code_o (q_w)
    );

    // Feedback value and next integrator states.
    always_comb begin
        fb_w = $signed({{FPAD{q_w[CODE_W-1]}}, q_w, {SH{1'b0}}});
        a1_w = $signed({{2{i1_q[IW-1]}}, i1_q}) + $signed({{(XW-DW){x_i[DW-1]}}, x_i})
             - $signed({{2{fb_w[IW-1]}}, fb_w});
        i1_n = sat_f(a1_w);
        a2_w = $signed({{2{i2_q[IW-1]}}, i2_q}) + $signed({{2{i1_n[IW-1]}}, i1_n})
             - $signed({{2{fb_w[IW-1]}}, fb_w});
        i2_n = sat_f(a2_w);
    end

    // Loop state and output registers, updated only on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i1_q    <= '0;
            i2_q    <= '0;
            code_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= en_i;
            if (en_i) begin
                i1_q   <= i1_n;
                i2_q   <= i2_n;
                code_o <= q_w;
            end
        end
    end

    assign i1_o = i1_q;
    assign i2_o = i2_q;
endmodule

// File: rtl/ms_modulator.sv
// Module: top of the dithered 17-level second-order modulator.
// Expects en_i at the oversampled rate (128x the audio frame rate); one
// sample in and one code out per enable. Dither step size is one quantizer
// step, i.e. 2^(DW-4) input units.
module ms_modulator
    import msdm_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          dith_en_i,
    input  logic [DW-1:0] sample_i,
    output logic [4:0]    code_o,
    output logic          valid_o
);
    localparam int SH   = DW - 4;
    localparam int DBW  = SH;
    localparam int ILIM = (1 << (IW - 2)) - 1;

    logic signed [DBW:0]  dith_w;
    logic signed [IW-1:0] i1_w, i2_w;
    code_t                code_w;

    msdm_dither #(.W(16), .DBW(DBW)) u_dither (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (en_i),
        .enable_i (dith_en_i),
        .dither_o (dith_w)
    );

    msdm_loop #(.DW(DW), .IW(IW), .SH(SH), .ILIM(ILIM)) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .x_i      ($signed(sample_i)),
        .dither_i (dith_w),
        .code_o   (code_w),
        .valid_o  (valid_o),
        .i1_o     (i1_w),
        .i2_o     (i2_w)
    );

    assign code_o = code_w;
endmodule

// File: rtl/ms_modulator_chk.sv
// Module: property checker bound to ms_modulator.
// Observes ports and the integrator and dither nets of the top.
module ms_modulator_chk #(
    parameter int IW   = 21,
    parameter int DBW  = 12,
    parameter int ILIM = 524287
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en_i,
    input logic                 dith_en_i,
    input logic signed [4:0]    code_o,
    input logic                 valid_o,
    input logic signed [IW-1:0] i1,
    input logic signed [IW-1:0] i2,
    input logic signed [DBW:0]  dither
);
    localparam logic signed [IW-1:0] LP = IW'(ILIM);
    localparam logic signed [IW-1:0] LN = -LP;
    localparam logic signed [DBW:0]  DMAX = (DBW+1)'((1 << DBW) - 2);
    localparam logic signed [DBW:0]  DMIN = (DBW+1)'(-(1 << DBW));

    a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o >= -5'sd8) && (code_o <= 5'sd8));
    a_r2_valid_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> valid_o);
    a_r9_hold_without_en: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!valid_o && $stable(code_o) && $stable(i1) && $stable(i2)));
    a_r6_i1_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (i1 <= LP) && (i1 >= LN));
    a_r6_i2_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (i2 <= LP) && (i2 >= LN));
    a_r7_dither_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dither <= DMAX) && (dither >= DMIN));
    a_r8_dither_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dith_en_i |-> (dither == '0));
endmodule

bind ms_modulator ms_modulator_chk #(.IW(IW), .DBW(DBW), .ILIM(ILIM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .dith_en_i (dith_en_i),
    .code_o    (code_w),
    .valid_o   (valid_o),
    .i1        (i1_w),
    .i2        (i2_w),
    .dither    (dith_w)
);

// File: tb/ms_modulator_tb.sv
`timescale 1ns/1ps
module ms_modulator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        dith_en_i = 1'b0;
    logic [15:0] sample_i = '0;
    logic [4:0]  code_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    longint m_i1, m_i2, m_code;
    logic [15:0] m_a, m_b;
    localparam longint LIM = 524287;

    always #2.5 clk = ~clk;

    ms_modulator u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .dith_en_i(dith_en_i),
        .sample_i(sample_i), .code_o(code_o), .valid_o(valid_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint satm(input longint v);
        if (v > LIM) return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    function automatic longint sx12(input logic [15:0] v);
        return longint'($signed(v[11:0]));
    endfunction

    // One enable of the reference model (R4, R5, R7, R8).
    task automatic model_step(input bit dith, input longint x);
        longint d, s, q, v;
        d = dith ? sx12(m_a) + sx12(m_b) : 0;
        s = m_i2 + d;
        q = (s + 2048) >>> 12;
        if (q > 8) q = 8;
        if (q < -8) q = -8;
        v = q * 4096;
        m_i1 = satm(m_i1 + x - v);
        m_i2 = satm(m_i2 + m_i1 - v);
        m_code = q;
        m_a = {m_a[14:0], ^(m_a & 16'hB400)};
        m_b = {m_b[14:0], ^(m_b & 16'hD008)};
    endtask

    function automatic longint cval();
        return longint'($signed(code_o));
    endfunction

    // Drive one cycle at a negedge, check at the next negedge.
    task automatic cyc(input bit en, input bit dith, input longint x, input string tag);
        en_i = en;
        dith_en_i = dith;
        sample_i = 16'(x);
        @(posedge clk);
        if (en) model_step(dith, x);
        @(negedge clk);
        if (en) begin
            chk(valid_o == 1'b1, "R2", longint'(valid_o), 1);
            chk(cval() == m_code, tag, cval(), m_code);
        end else begin
            chk(valid_o == 1'b0, "R9", longint'(valid_o), 0);
            chk(cval() == m_code, "R9", cval(), m_code);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_i1 = 0; m_i2 = 0; m_code = 0;
        m_a = 16'hACE1; m_b = 16'h1D2B;
        chk(cval() == 0, "R1", cval(), 0);
        chk(valid_o == 1'b0, "R1", longint'(valid_o), 0);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        longint sum, x, mean;
        void'($urandom(32'd20240611));
        do_reset();

        // R10: zero input, dither off, idle codes all zero.
        for (int k = 0; k < 200; k++) begin
            cyc(1'b1, 1'b0, 0, "R10");
            chk(cval() == 0, "R10", cval(), 0);
        end

        // R9: gaps between enables with a changing sample.
        for (int k = 0; k < 600; k++) begin
            bit e = ($urandom_range(0, 2) == 0);
            cyc(e, 1'b1, longint'($signed(16'($urandom))), e ? "R4" : "R9");
        end

        // R4/R5/R7: random moderate inputs, dither on, random enable gaps.
        for (int k = 0; k < 2000; k++) begin
            bit e = ($urandom_range(0, 3) != 0);
            x = longint'($urandom_range(0, 40000)) - 20000;
            cyc(e, 1'b1, x, "R7");
        end

        // R8: triangle-wave input with dither toggled at random.
        for (int k = 0; k < 2000; k++) begin
            longint ph = k % 256;
            x = (ph < 128) ? (ph * 400 - 25600) : ((255 - ph) * 400 - 25600);
            cyc(1'b1, $urandom_range(0, 1) == 1, x, "R8");
        end

        // R6/R3: sustained full scale both ways with dither: clamp and saturation together.
        for (int k = 0; k < 600; k++) begin
            cyc(1'b1, 1'b1, 32767, "R6");
            chk(cval() <= 8 && cval() >= -8, "R3", cval(), 8);
        end
        for (int k = 0; k < 600; k++) begin
            cyc(1'b1, 1'b1, -32768, "R6");
            chk(cval() <= 8 && cval() >= -8, "R3", cval(), -8);
        end

        // R1: reset mid-run restores integrators and generator seeds.
        do_reset();
        for (int k = 0; k < 50; k++) cyc(1'b1, 1'b1, 1234, "R1");

        // R11: DC tracking of the code mean.
        do_reset();
        sum = 0;
        for (int k = 0; k < 4096; k++) begin
            cyc(1'b1, 1'b1, 10000, "R5");
            sum += cval();
        end
        mean = sum;
        chk((mean >= 10000 - 200) && (mean <= 10000 + 200), "R11", mean, 10000);

        do_reset();
        sum = 0;
        for (int k = 0; k < 4096; k++) begin
            cyc(1'b1, 1'b0, -21000, "R5");
            sum += cval();
        end
        chk((sum >= -21000 - 200) && (sum <= -21000 + 200), "R11", sum, -21000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule